// File: doc/BRIEF.md
# Sticky Fault Status Register

This block keeps a byte-wide status register for a power converter controller. Four level fault indicators (short circuit, overcurrent, overvoltage and thermal shutdown) pass through a synchronizer. Each one then sets its own sticky bit, and that bit stays set until software reads the register. The low two bits carry the converter's present operating mode. That mode is sampled from a live two-bit code.

An active-low interrupt line is pulled low while any sticky fault bit is set and the matching bit of an externally held mask byte is also set. Software services the interrupt by reading the status address. The read returns the value the register held before the clear. The fault bits and the interrupt release on the next clock edge. A fault that is still present sets its bit again at once, and the interrupt returns. Only a generic read strobe with an address is modelled. The bus protocol around it is not.

Top module: `fault_status_reg`

## Requirements
- R1: Read data layout: bit 7 short circuit, bit 6 overcurrent, bit 5 overvoltage, bit 4 thermal shutdown, bits 3 and 2 always zero, bits 1..0 operating mode.
- R2: Once a fault bit is set it stays set, regardless of its fault input, until the status address is read.
- R3: A read strobe at the status address (07h) clears all four fault bits on the clock edge that ends the read cycle.
- R4: The interrupt output is low exactly when some fault bit is set and the mask bit at the same position (mask bits 7..4) is 1. It follows a mask change in the same cycle.
- R5: Mask bits 3..0 have no effect on the interrupt.
- R6: A fault input that is still active across a clearing read keeps its bit set, and the interrupt stays or comes back low.
- R7: During a status read cycle the read data shows the register value from before the clear.
- R8: A fault whose synchronized level reaches the latch on the same edge as the clearing read is kept set, and no event is lost.
- R9: After reset the fault bits are 0, the mode field is 01 and the interrupt output is high.
- R10: The mode field takes the live mode code (00 boost, 01 buck, 10 buck-boost, 11 reserved) one clock edge after it is applied.
- R11: A fault input change reaches its sticky bit on the third rising edge after it is applied: two synchronizer stages, then the latch.
- R12: A read strobe at any other address returns zero and leaves the fault bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_short_i | input | 1 | Short-circuit fault level |
| flt_ocur_i | input | 1 | Overcurrent fault level |
| flt_ovolt_i | input | 1 | Overvoltage fault level |
| flt_therm_i | input | 1 | Thermal shutdown fault level |
| mode_i | input | 2 | Live operating mode code |
| mask_i | input | 8 | Interrupt mask byte (bits 7..4 used) |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Read data, zero unless the status address is read |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
A fault input reaches the interrupt three rising edges after it is applied. A mode change shows in the read data one edge after it is applied. A mask change acts on the interrupt within the same cycle, and read data is valid within the strobe cycle itself. The clear lands on the edge that ends the read. The bench drives every input on a falling edge. It then counts falling edges to the edge where each result is due and samples just after the falling edge. Every latency check also samples once one edge early, to confirm the result is not there yet. The same-edge case places the read strobe in the cycle where the synchronized fault reaches the latch.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int FLT_N    = 4;
   localparam int MODE_W   = 2;
   localparam int DATA_W   = 8;
   localparam int FLT_LSB  = DATA_W - FLT_N;
   localparam int RSVD_W   = FLT_LSB - MODE_W;

   typedef enum logic [MODE_W-1:0] {
      MODE_BOOST     = 2'b00,
      MODE_BUCK      = 2'b01,
      MODE_BUCKBOOST = 2'b10,
      MODE_RSVD      = 2'b11
   } op_mode_e;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fsr_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg_q[s] <= '0;
         else if (s == 0) stg_q[s] <= async_i;
         else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/fsr_sticky.sv
module fsr_sticky #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] bits_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("fsr_sticky: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        bits_o[b] <= 1'b0;
         else if (set_i[b]) bits_o[b] <= 1'b1;   // set beats clear
         else if (clr_i)    bits_o[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/fsr_compose.sv
module fsr_compose
   import fsr_pkg::*;
(
   input  logic [FLT_N-1:0]  sticky_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic              rd_hit_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_n_o
);
   logic [DATA_W-1:0] image;
   logic [FLT_N-1:0]  armed;

   always_comb begin
      image                           = '0;
      image[DATA_W-1:FLT_LSB]         = sticky_i;
      image[FLT_LSB-1:MODE_W]         = '0;
      image[MODE_W-1:0]               = mode_i;
   end

   assign armed     = sticky_i & mask_i[DATA_W-1:FLT_LSB];
   assign irq_n_o   = ~(|armed);
   assign rd_data_o = rd_hit_i ? image : '0;
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
   import fsr_pkg::*;
#(
   parameter int                 ADDR_W      = 8,
   parameter logic [ADDR_W-1:0]  STATUS_ADDR = 8'h07,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [MODE_W-1:0]  MODE_RESET  = MODE_BUCK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flt_short_i,
   input  logic              flt_ocur_i,
   input  logic              flt_ovolt_i,
   input  logic              flt_therm_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_n_o
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("fault_status_reg: ADDR_W must be positive");
   end
   if (RSVD_W < 0) begin : g_bad_layout
      $error("fault_status_reg: fault and mode fields overlap");
   end

   logic [FLT_N-1:0]  raw_flt;
   logic [FLT_N-1:0]  sync_flt;
   logic [FLT_N-1:0]  sticky_q;
   logic [MODE_W-1:0] mode_q;
   logic              rd_hit;

   // index 3..0 maps onto data bits 7..4
   assign raw_flt = {flt_short_i, flt_ocur_i, flt_ovolt_i, flt_therm_i};
   assign rd_hit  = rd_en_i && (rd_addr_i == STATUS_ADDR);

   fsr_sync #(.WIDTH(FLT_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_flt),
      .sync_o  (sync_flt)
   );

   fsr_sticky #(.WIDTH(FLT_N)) u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (sync_flt),
      .clr_i  (rd_hit),
      .bits_o (sticky_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_RESET;
      else        mode_q <= mode_i;
   end

   fsr_compose u_compose (
      .sticky_i  (sticky_q),
      .mode_i    (mode_q),
      .mask_i    (mask_i),
      .rd_hit_i  (rd_hit),
      .rd_data_o (rd_data_o),
      .irq_n_o   (irq_n_o)
   );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
   import fsr_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              rd_hit,
   input logic [FLT_N-1:0]  sync_flt,
   input logic [FLT_N-1:0]  sticky,
   input logic [DATA_W-1:0] mask_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              irq_n_o
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[FLT_LSB-1:MODE_W] == '0);                                       // R1
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> ((sticky & $past(sticky)) == $past(sticky)));                 // R2
   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && sync_flt == '0) |=> (sticky == '0));                           // R3
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n_o == !(|(sticky & mask_i[DATA_W-1:FLT_LSB])));                      // R4
   AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_flt != '0) |=> ((sticky & $past(sync_flt)) == $past(sync_flt)));    // R8
   AST_PRECLEAR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> (rd_data_o[DATA_W-1:FLT_LSB] == sticky));                      // R7
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_data_o == '0));                                           // R12
endmodule

bind fault_status_reg fsr_checker chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_hit    (rd_hit),
   .sync_flt  (sync_flt),
   .sticky    (sticky_q),
   .mask_i    (mask_i),
   .rd_data_o (rd_data_o),
   .irq_n_o   (irq_n_o)
);

// File: tb/fault_status_reg_tb_top.sv
`timescale 1ns/1ps
module fault_status_reg_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       f_short = 0, f_ocur = 0, f_ovolt = 0, f_therm = 0;
   logic [1:0] mode = 2'b01;
   logic [7:0] mask = 8'h00;
   logic       rd_en = 0;
   logic [7:0] rd_addr = 8'h00;
   logic [7:0] rd_data;
   logic       irq_n;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fault_status_reg dut_i (
      .clk(clk), .rst_n(rst_n),
      .flt_short_i(f_short), .flt_ocur_i(f_ocur),
      .flt_ovolt_i(f_ovolt), .flt_therm_i(f_therm),
      .mode_i(mode), .mask_i(mask),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .irq_n_o(irq_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // read strobe for one cycle; data sampled inside the cycle
   task automatic do_read(input logic [7:0] addr, output logic [7:0] data);
      rd_en = 1; rd_addr = addr;
      #1 data = rd_data;
      step(1);
      rd_en = 0;
   endtask

   task automatic chk_irq(input logic exp, input string req);
      #1 check(irq_n === exp, req, irq_n, exp);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk_irq(1'b1, "R9 irq after reset");
      do_read(8'h07, d);
      check(d === 8'h01, "R9 reset value", d, 8'h01);
   endtask

   task automatic t_mode();
      logic [7:0] d;
      mode = 2'b10; #1 ;
      do_read(8'h07, d);
      check(d === 8'h01, "R10 mode not yet", d, 8'h01);
      do_read(8'h07, d);
      check(d === 8'h02, "R10 buck-boost", d, 8'h02);
      mode = 2'b00; step(1);
      do_read(8'h07, d);
      check(d === 8'h00, "R10 boost", d, 8'h00);
      mode = 2'b11; step(1);
      do_read(8'h07, d);
      check(d === 8'h03, "R10 reserved code", d, 8'h03);
      mode = 2'b01; step(1);
   endtask

   task automatic t_sticky();
      logic [7:0] d;
      mask = 8'hF0;
      f_short = 1; step(1); f_short = 0;
      step(1);
      chk_irq(1'b1, "R11 not latched after two edges");
      step(1);
      chk_irq(1'b0, "R11 latched on third edge");
      step(10);
      chk_irq(1'b0, "R2 stays set after input drops");
      do_read(8'h07, d);
      check(d === 8'h81, "R7 pre-clear data", d, 8'h81);
      chk_irq(1'b1, "R3 irq released after read");
      do_read(8'h07, d);
      check(d === 8'h01, "R3 bits cleared", d, 8'h01);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      mask = 8'h0F;
      f_ocur = 1; step(1); f_ocur = 0;
      step(4);
      chk_irq(1'b1, "R5 low mask bits ignored");
      mask = 8'h40;
      chk_irq(1'b0, "R4 matching mask bit");
      mask = 8'h80;
      chk_irq(1'b1, "R4 other mask bit");
      step(1);
      do_read(8'h07, d);
      check(d === 8'h41, "R1 overcurrent at bit 6", d, 8'h41);
      check(d[3:2] === 2'b00, "R1 reserved zero", d[3:2], 0);
   endtask

   task automatic t_other_addr();
      logic [7:0] d;
      mask = 8'hFF;
      f_ovolt = 1; step(1); f_ovolt = 0;
      step(4);
      do_read(8'h05, d);
      check(d === 8'h00, "R12 other address reads zero", d, 8'h00);
      chk_irq(1'b0, "R12 other address keeps bits");
      do_read(8'h07, d);
      check(d === 8'h21, "R1 overvoltage at bit 5", d, 8'h21);
   endtask

   task automatic t_persist();
      logic [7:0] d;
      mask = 8'h10;
      f_therm = 1; step(3);
      do_read(8'h07, d);
      check(d === 8'h11, "R1 thermal at bit 4", d, 8'h11);
      chk_irq(1'b0, "R6 irq held with active fault");
      do_read(8'h07, d);
      check(d === 8'h11, "R6 bit set again", d, 8'h11);
      f_therm = 0; step(3);
      do_read(8'h07, d);
      check(d === 8'h11, "R2 last latched value", d, 8'h11);
      do_read(8'h07, d);
      check(d === 8'h01, "R6 clears once fault gone", d, 8'h01);
      chk_irq(1'b1, "R6 irq released");
   endtask

   task automatic t_same_edge();
      logic [7:0] d;
      mask = 8'h80;
      f_short = 1; step(1); f_short = 0;
      step(1);
      do_read(8'h07, d);   // clear lands on the latching edge
      check(d === 8'h01, "R8 data before latch", d, 8'h01);
      chk_irq(1'b0, "R8 fault kept over clear");
      do_read(8'h07, d);
      check(d === 8'h81, "R8 event not lost", d, 8'h81);
      do_read(8'h07, d);
      check(d === 8'h01, "R3 cleared afterwards", d, 8'h01);
   endtask

   initial begin
      step(3);
      rst_n = 1;
      step(2);
      t_reset();
      t_mode();
      t_sticky();
      t_mask();
      t_other_addr();
      t_persist();
      t_same_edge();
      step(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule